// File: doc/BRIEF.md
# Three-Wire Panel Register Writer

This block is a serial master that programs one register of a display panel per request. It uses three output wires: an active-low enable, a serial clock that rests high, and a data line. A client offers an 8-bit register address and an 8-bit value on a valid/ready request port. The block then emits a 16-bit frame on the wires. The frame carries the address in the upper byte and the value in the lower byte, and bits go out most significant first. The panel captures each bit on the rising edge of the serial clock.

Every interval in the frame is a parameter counted in system clock cycles:
- the setup time from enable falling to the first clock fall;
- the low and high half-periods of each bit;
- the hold time after enable returns high.

A build-time option changes the transmitted address byte to the address shifted left by two with binary `10` in the low bits. The same option adds a further gap after the hold time. The request port applies back-pressure for the whole frame: `req_ready` is high only while the block is idle. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. The client may hold `req_valid` high for as long as it likes, and a request offered while the block is busy waits without effect. The address and value are copied on acceptance, so the client may change them afterwards.

Top module: `pnl3w_writer`

## Requirements
- R1: While idle, `pnl_en_n` is 1, `pnl_sclk` is 1, `pnl_sdata` is 0, `req_ready` is 1 and `busy` is 0.
- R2: A request is accepted on the rising edge where `req_valid` and `req_ready` are both 1. `pnl_en_n` goes low in the next cycle and stays low for `SETUP_CYC` cycles before the first clock fall.
- R3: In plain mode the frame word is `{req_addr, req_data}` as captured at acceptance. Bit k of the transfer (k = 0..15) carries frame bit 15-k, so the most significant bit goes first.
- R4: Each bit has `pnl_sclk` low for `HALF_CYC` cycles and then high for `HALF_CYC` cycles. `pnl_sdata` holds the bit across both halves.
- R5: After the high half of the 16th bit, `pnl_en_n` returns to 1 and the block stays busy for `HOLD_CYC` cycles.
- R6: With `ENC_ADDR` = 1, the upper frame byte is `{req_addr[5:0], 2'b10}`. A further `GAP_CYC` busy cycles follow the hold, with enable high.
- R7: `req_ready` is 0 and `busy` is 1 from acceptance until the frame and its hold/gap end. A `req_valid` or a change of address or value during that time has no effect on the frame in flight.
- R8: `done` is 1 for exactly one cycle: the first idle cycle after the hold, or after the gap in encoded mode.
- R9: A synchronous `rst` aborts any frame. In the next cycle the outputs are at the R1 levels and `done` is 0.
- R10: `pnl_sdata` is 0 outside the bit phases, which includes the setup and hold intervals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 8 | Panel register address |
| req_data | input | 8 | Value to write |
| busy | output | 1 | Frame, hold or gap in progress |
| done | output | 1 | One-cycle pulse when a write completes |
| pnl_en_n | output | 1 | Panel enable, active low |
| pnl_sclk | output | 1 | Serial clock, idle high |
| pnl_sdata | output | 1 | Serial data |

## Verification
Two situations are hard to reach from the ports. The first is a request held through a busy frame, with its address and value changed while the frame is on the wires. The bench raises `req_valid` straight after an acceptance and alters the fields mid-frame. The shifted bits must still match the captured word, and the pending request must be taken on the first idle edge after `done`. The second is a reset landing inside a low clock half. The bench places a one-cycle `rst` in the middle of a frame and compares the wire levels on the following cycle.

// File: rtl/pnl3w_pkg.sv
package pnl3w_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_LOW   = 3'd2,
    ST_HIGH  = 3'd3,
    ST_HOLD  = 3'd4,
    ST_GAP   = 3'd5
  } wr_state_t;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/pnl3w_frame.sv
module pnl3w_frame #(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 8,
  parameter bit ENC_ADDR = 1'b0,
  localparam int FRAME_W = ADDR_W + DATA_W
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic [DATA_W-1:0]  data,
  output logic [FRAME_W-1:0] word
);
  logic [ADDR_W-1:0] addr_byte;

  generate
    if (ENC_ADDR) begin : g_enc
      logic [ADDR_W+1:0] widened;
      assign widened   = {addr, 2'b10};
      assign addr_byte = widened[ADDR_W-1:0];
    end else begin : g_plain
      assign addr_byte = addr;
    end
  endgenerate

  assign word = {addr_byte, data};
endmodule

// File: rtl/pnl3w_timer.sv
module pnl3w_timer #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (load) begin
      cnt <= load_val;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/pnl3w_shift.sv
module pnl3w_shift #(
  parameter int FRAME_W = 16,
  localparam int BCW = (FRAME_W > 1) ? $clog2(FRAME_W) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic [FRAME_W-1:0] word,
  input  logic               advance,
  output logic               cur_bit,
  output logic               last_bit
);
  logic [FRAME_W-1:0] sr;
  logic [BCW-1:0]     idx;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr  <= '0;
      idx <= '0;
    end else if (load) begin
      sr  <= word;
      idx <= '0;
    end else if (advance) begin
      sr  <= {sr[FRAME_W-2:0], 1'b0};
      idx <= idx + 1'b1;
    end
  end

  assign cur_bit  = sr[FRAME_W-1];
  assign last_bit = (idx == BCW'(FRAME_W - 1));
endmodule

// File: rtl/pnl3w_writer.sv
module pnl3w_writer
  import pnl3w_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 8,
  parameter int SETUP_CYC = 2500,
  parameter int HALF_CYC  = 2500,
  parameter int HOLD_CYC  = 10000,
  parameter int GAP_CYC   = 10000,
  parameter bit ENC_ADDR  = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              busy,
  output logic              done,
  output logic              pnl_en_n,
  output logic              pnl_sclk,
  output logic              pnl_sdata
);
  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int MAX_D   = max4(SETUP_CYC, HALF_CYC, HOLD_CYC, GAP_CYC);
  localparam int CW      = $clog2(MAX_D + 1);

  wr_state_t         state, state_nx;
  logic              tmr_load;
  logic [CW-1:0]     tmr_val;
  logic              tmr_exp;
  logic              accept;
  logic              advance;
  logic              cur_bit;
  logic              last_bit;
  logic              finish;
  logic [FRAME_W-1:0] word;

  pnl3w_frame #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .ENC_ADDR(ENC_ADDR)
  ) u_frame (
    .addr(req_addr),
    .data(req_data),
    .word(word)
  );

  pnl3w_timer #(.CW(CW)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .load    (tmr_load),
    .load_val(tmr_val),
    .expired (tmr_exp)
  );

  pnl3w_shift #(.FRAME_W(FRAME_W)) u_shift (
    .clk     (clk),
    .rst     (rst),
    .load    (accept),
    .word    (word),
    .advance (advance),
    .cur_bit (cur_bit),
    .last_bit(last_bit)
  );

  assign accept = (state == ST_IDLE) && req_valid;

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    tmr_val  = '0;
    advance  = 1'b0;
    finish   = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (req_valid) begin
          state_nx = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = CW'(SETUP_CYC - 1);
        end
      end
      ST_SETUP: begin
        if (tmr_exp) begin
          state_nx = ST_LOW;
          tmr_load = 1'b1;
          tmr_val  = CW'(HALF_CYC - 1);
        end
      end
      ST_LOW: begin
        if (tmr_exp) begin
          state_nx = ST_HIGH;
          tmr_load = 1'b1;
          tmr_val  = CW'(HALF_CYC - 1);
        end
      end
      ST_HIGH: begin
        if (tmr_exp) begin
          tmr_load = 1'b1;
          if (last_bit) begin
            state_nx = ST_HOLD;
            tmr_val  = CW'(HOLD_CYC - 1);
          end else begin
            state_nx = ST_LOW;
            tmr_val  = CW'(HALF_CYC - 1);
            advance  = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        if (tmr_exp) begin
          if (ENC_ADDR) begin
            state_nx = ST_GAP;
            tmr_load = 1'b1;
            tmr_val  = CW'(GAP_CYC - 1);
          end else begin
            state_nx = ST_IDLE;
            finish   = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (tmr_exp) begin
          state_nx = ST_IDLE;
          finish   = 1'b1;
        end
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      done  <= 1'b0;
    end else begin
      state <= state_nx;
      done  <= finish;
    end
  end

  assign req_ready = (state == ST_IDLE);
  assign busy      = (state != ST_IDLE);
  assign pnl_en_n  = !((state == ST_SETUP) || (state == ST_LOW) || (state == ST_HIGH));
  assign pnl_sclk  = (state != ST_LOW);
  assign pnl_sdata = ((state == ST_LOW) || (state == ST_HIGH)) ? cur_bit : 1'b0;
endmodule

// File: rtl/pnl3w_checker.sv
module pnl3w_checker (
  input logic clk,
  input logic rst,
  input logic req_valid,
  input logic req_ready,
  input logic busy,
  input logic done,
  input logic pnl_en_n,
  input logic pnl_sclk,
  input logic pnl_sdata
);
  assert_idle_levels_R1: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (pnl_en_n && pnl_sclk && !pnl_sdata && !busy));

  assert_enable_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
    ($fell(pnl_en_n) && !$past(rst)) |-> $past(req_valid && req_ready));

  assert_clock_framed_R4: assert property (@(posedge clk) disable iff (rst)
    !pnl_sclk |-> !pnl_en_n);

  assert_data_stable_R4: assert property (@(posedge clk) disable iff (rst)
    ($rose(pnl_sclk) && !$past(rst)) |-> $stable(pnl_sdata));

  assert_data_low_disabled_R10: assert property (@(posedge clk) disable iff (rst)
    pnl_en_n |-> !pnl_sdata);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> req_ready);

  assert_ready_return_R7: assert property (@(posedge clk) disable iff (rst)
    ($rose(req_ready) && !$past(rst)) |-> done);

  assert_reset_idle_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (req_ready && pnl_en_n && pnl_sclk && !pnl_sdata && !done));
endmodule

bind pnl3w_writer pnl3w_checker u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .busy     (busy),
  .done     (done),
  .pnl_en_n (pnl_en_n),
  .pnl_sclk (pnl_sclk),
  .pnl_sdata(pnl_sdata)
);

// File: tb/tb_pnl3w_writer.sv
module tb_pnl3w_writer;
  localparam int S = 3;
  localparam int H = 2;
  localparam int P = 5;
  localparam int G = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       va [2];
  logic [7:0] aa = 8'h00;
  logic [7:0] dd = 8'h00;
  logic       rdy [2], bsy [2], dn [2], en_n [2], sck [2], sda [2];

  int nchk = 0;
  int nfail = 0;
  bit started = 1'b0;
  bit finished = 1'b0;

  int          mt [2];
  logic [15:0] mw [2];
  bit          mdone [2];

  always #5 clk = ~clk;

  pnl3w_writer #(.SETUP_CYC(S), .HALF_CYC(H), .HOLD_CYC(P), .GAP_CYC(G), .ENC_ADDR(1'b0)) dut (
    .clk(clk), .rst(rst), .req_valid(va[0]), .req_ready(rdy[0]),
    .req_addr(aa), .req_data(dd), .busy(bsy[0]), .done(dn[0]),
    .pnl_en_n(en_n[0]), .pnl_sclk(sck[0]), .pnl_sdata(sda[0]));

  pnl3w_writer #(.SETUP_CYC(S), .HALF_CYC(H), .HOLD_CYC(P), .GAP_CYC(G), .ENC_ADDR(1'b1)) dut_enc (
    .clk(clk), .rst(rst), .req_valid(va[1]), .req_ready(rdy[1]),
    .req_addr(aa), .req_data(dd), .busy(bsy[1]), .done(dn[1]),
    .pnl_en_n(en_n[1]), .pnl_sclk(sck[1]), .pnl_sdata(sda[1]));

  function automatic int total_len(input int i);
    return S + 32 * H + P + ((i == 1) ? G : 0);
  endfunction

  // Behavioural reference: elapsed-cycle counter per instance
  always @(posedge clk) begin
    started <= 1'b1;
    for (int i = 0; i < 2; i++) begin
      if (rst) begin
        mt[i]    <= -1;
        mdone[i] <= 1'b0;
      end else if (mt[i] < 0) begin
        mdone[i] <= 1'b0;
        if (va[i]) begin
          mt[i] <= 0;
          mw[i] <= (i == 1) ? {aa[5:0], 2'b10, dd} : {aa, dd};
        end
      end else if (mt[i] == total_len(i) - 1) begin
        mt[i]    <= -1;
        mdone[i] <= 1'b1;
      end else begin
        mt[i]    <= mt[i] + 1;
        mdone[i] <= 1'b0;
      end
    end
  end

  task automatic chk(input string tag, input string what, input logic act, input logic exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      for (int i = 0; i < 2; i++) begin
        int t;
        int k;
        int ph;
        logic e_en, e_sck, e_sda;
        string dtag;
        t = mt[i];
        e_en = 1'b1; e_sck = 1'b1; e_sda = 1'b0; dtag = "R10";
        if (t >= 0 && t < S + 32 * H) e_en = 1'b0;
        if (t >= S && t < S + 32 * H) begin
          k  = (t - S) / (2 * H);
          ph = (t - S) % (2 * H);
          e_sck = (ph >= H);
          e_sda = mw[i][15 - k];
          dtag = (i == 1 && k < 8) ? "R6" : "R3";
        end
        chk((t < 0) ? "R1" : "R7", "req_ready", rdy[i], (t < 0));
        chk((t < 0) ? "R1" : "R7", "busy", bsy[i], (t >= 0));
        chk((t >= S + 32 * H) ? ((i == 1 && t >= S + 32 * H + P) ? "R6" : "R5") : "R2",
            "pnl_en_n", en_n[i], e_en);
        chk("R4", "pnl_sclk", sck[i], e_sck);
        chk(dtag, "pnl_sdata", sda[i], e_sda);
        chk("R8", "done", dn[i], mdone[i]);
      end
    end
  end

  task automatic send(input int i, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    va[i] = 1'b1; aa = a; dd = d;
    while (!rdy[i]) @(negedge clk);
    @(negedge clk);
    va[i] = 1'b0;
  endtask

  task automatic wait_idle(input int i);
    @(negedge clk);
    while (!rdy[i]) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  endtask

  initial begin
    va[0] = 1'b0; va[1] = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);            // R1 idle levels observed here
    // R3 R4 R5 plain frames with varied patterns
    send(0, 8'hA5, 8'h3C); wait_idle(0);
    send(0, 8'hFF, 8'h00); wait_idle(0);
    send(0, 8'h00, 8'hFF); wait_idle(0);
    // R7: valid held through busy, fields changed mid-frame
    send(0, 8'h80, 8'h01);
    va[0] = 1'b1; aa = 8'h5A; dd = 8'hC3;
    repeat (10) @(negedge clk);
    aa = 8'h12; dd = 8'h34;               // captured when ready returns
    while (!rdy[0]) @(negedge clk);
    @(negedge clk);
    aa = 8'hEE; dd = 8'h77;               // R7 change after acceptance, ignored
    va[0] = 1'b0;
    wait_idle(0);
    // R9 reset inside a frame
    send(0, 8'h69, 8'h96);
    repeat (S + 3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // R6 encoded address with gap
    send(1, 8'h05, 8'h5D); wait_idle(1);
    send(1, 8'hFF, 8'h81); wait_idle(1);
    // back-to-back in encoded mode
    va[1] = 1'b1; aa = 8'h3B; dd = 8'h42;
    repeat (2 * total_len(1) + 4) @(negedge clk);
    va[1] = 1'b0;
    wait_idle(1);
    repeat (4) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    nchk++;
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end
endmodule